// File: doc/BRIEF.md
# Byte-Oriented I2C Master Controller

This block is a single-master I2C controller. Software runs it through five byte-wide registers on a simple memory-mapped bus. The controller generates START, repeated START and STOP conditions on an open-drain bus. It shifts one byte at a time, handles the acknowledge slot in both directions, and raises an interrupt flag when each byte completes. Each bus line is modelled as a pull-low enable plus a sensed input. A board pull-up makes a released line read high.

Software selects a direction bit and then works the data register. Writing the data register sends a byte. Reading the data register arms the reception of the next byte. After each byte the controller holds SCL low until software acts again. An elaboration parameter sets the register stride. Two more parameters set how the interrupt flag is cleared and the active level of the enable bit. The bit rate comes from a divider code, which a fixed non-linear mapping turns into an SCL period.

Top module: `i2c_byte_master`

## Requirements
- R1: Register index k (0 own address, 1 divider code, 2 control, 3 status, 4 data) sits at byte offset k << REG_SHIFT (default 2). An access whose low REG_SHIFT address bits are not zero is ignored and reads 0. Every register resets to 0, and own address, divider and control read back what was written.
- R2: With the module enabled, control bit5 (master) at 1 while idle produces a START: SDA falls while SCL is high. Status bit5 (bus busy) sets on the observed START, and SCL is then held low.
- R3: With control bit4 (transmit) at 1 and the controller holding, a data-register write sends the byte MSB first. SDA is released on the ninth clock, and the level sampled there is stored in status bit0 (1 = not acknowledged).
- R4: At the end of the ninth clock, status bit1 (byte-done flag) and status bit7 (transfer complete) set. SCL then stays low with no further clocks until software acts.
- R5: With control bit4 at 0 and the controller holding, a data-register read returns the current data byte and starts reception of one byte, MSB first, into the data register. In the acknowledge slot SDA is driven low when control bit3 is 0 and released when it is 1.
- R6: Clearing control bit5 while holding issues no further data clocks. It makes a STOP (one SCL rise, then SDA rises while SCL is high), and status bit5 then clears.
- R7: Setting control bit2 while bit5 is held makes a repeated START with no STOP in between. Bus busy stays set, and control bit2 reads 0 once the restart begins.
- R8: With the default CLR_W1C=0, a status write with bit1 = 0 clears the byte-done flag and a write with bit1 = 1 leaves it. CLR_W1C=1 inverts this.
- R9: With the default EN_LOW=0, the module is enabled when control bit7 is 1. While disabled, both lines are released, no START is made, bus busy reads 0 and any transfer is abandoned. EN_LOW=1 inverts the enable level.
- R10: The SCL period equals the ratio selected by divider bits [5:0], in system clocks: 0x20 gives 22, 0x00 gives 30, 0x2A gives 64, 0x3F gives 2048 and 0x1F gives 3840.
- R11: The irq output is the byte-done flag gated by control bit6.
- R12: Within a byte, the controller changes SDA only while SCL is low.
- R13: If a byte completes in the same cycle as a clearing status write, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on the data register only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | Sensed SCL level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The completion of a byte and a software clear of the byte-done flag can land on the same clock edge. The bench triggers this by writing the data register and then counting exactly nine SCL periods, so that the status write is sampled on the edge where the ninth clock ends. It judges the outcome by reading the flag back as still set. A second clear one cycle later must then take effect.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int unsigned REG_SHIFT = 2,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CNT_W     = 12,
  parameter bit          CLR_W1C   = 1'b0,
  parameter bit          EN_LOW    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  localparam logic [2:0] S_IDLE = 3'd0, S_START = 3'd1, S_HOLD = 3'd2,
                         S_BYTE = 3'd3, S_RSTA = 3'd4, S_STOP = 3'd5;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << REG_SHIFT) - 1);

  function automatic logic [CNT_W-1:0] ratio_of(input logic [5:0] c);
    int g, m, v, mant;
    g = int'(c[4:2]);
    m = int'(c[1:0]);
    if (c[5]) begin
      if (g == 0)      v = 22 + 2 * m;
      else if (g == 1) v = 32 + 4 * m;
      else if (g == 2) v = 48 + 8 * m;
      else             v = (5 + m) << (g + 1);
    end else if (g < 3) begin
      case (g * 4 + m)
        0: v = 30;   1: v = 32;   2: v = 36;   3: v = 42;
        4: v = 48;   5: v = 52;   6: v = 60;   7: v = 72;
        8: v = 80;   9: v = 88;  10: v = 104; default: v = 128;
      endcase
    end else begin
      mant = (m == 0) ? 9 : (m == 1) ? 10 : (m == 2) ? 12 : 15;
      v = mant << (g + 1);
    end
    return CNT_W'(v);
  endfunction

  logic [7:0] own_q, div_q, ctrl_q, dat_q;
  logic       iif_q, rxak_q, tcf_q, busy_q, rx_q, sda_oe_q, scl_q, sda_q;
  logic [2:0] st;
  logic [CNT_W-1:0] cnt;
  logic [3:0] bitn;

  wire              en    = ctrl_q[7] ^ EN_LOW;
  wire [ADDR_W-1:0] idx   = bus_addr >> REG_SHIFT;
  wire              hit   = (bus_addr & LOW_MASK) == '0;
  wire              wr_own  = bus_wr & hit & (idx == ADDR_W'(0));
  wire              wr_div  = bus_wr & hit & (idx == ADDR_W'(1));
  wire              wr_ctl  = bus_wr & hit & (idx == ADDR_W'(2));
  wire              wr_stat = bus_wr & hit & (idx == ADDR_W'(3));
  wire              wr_dat  = bus_wr & hit & (idx == ADDR_W'(4));
  wire              rd_dat  = bus_rd & hit & (idx == ADDR_W'(4));

  wire [CNT_W-1:0] ratio = ratio_of(div_q[5:0]);
  wire [CNT_W-1:0] half  = ratio >> 1;
  wire [CNT_W-1:0] qtr   = ratio >> 2;
  wire [CNT_W-1:0] smp   = half + qtr;
  wire             cnt_end   = cnt == ratio - CNT_W'(1);
  wire             byte_done = (st == S_BYTE) && (bitn == 4'd8) && cnt_end;
  wire             clr_hit   = CLR_W1C ? bus_wdata[1] : ~bus_wdata[1];
  wire             start_ev  = scl_in & scl_q & sda_q & ~sda_in;
  wire             stop_ev   = scl_in & scl_q & ~sda_q & sda_in;

  assign scl_oe = (st == S_HOLD)
                | (((st == S_BYTE) | (st == S_RSTA) | (st == S_STOP)) & (cnt < half))
                | ((st == S_START) & (cnt >= half));
  assign sda_oe = sda_oe_q;
  assign irq    = iif_q & ctrl_q[6];

  always_comb begin
    bus_rdata = 8'h00;
    if (hit)
      case (idx)
        ADDR_W'(0): bus_rdata = own_q;
        ADDR_W'(1): bus_rdata = div_q;
        ADDR_W'(2): bus_rdata = ctrl_q;
        ADDR_W'(3): bus_rdata = {tcf_q, 1'b0, busy_q, 3'b000, iif_q, rxak_q};
        ADDR_W'(4): bus_rdata = dat_q;
        default:    bus_rdata = 8'h00;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0; div_q <= '0; ctrl_q <= '0; dat_q <= '0;
      iif_q <= 1'b0; rxak_q <= 1'b0; tcf_q <= 1'b0; busy_q <= 1'b0;
      rx_q <= 1'b0; sda_oe_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
      st <= S_IDLE; cnt <= '0; bitn <= '0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (wr_own) own_q <= bus_wdata;
      if (wr_div) div_q <= bus_wdata;
      if (wr_ctl) ctrl_q <= bus_wdata;
      else if (st == S_HOLD && en && ctrl_q[5] && ctrl_q[2]) ctrl_q[2] <= 1'b0;
      if (wr_dat) dat_q <= bus_wdata;
      if (byte_done) iif_q <= 1'b1;
      else if (wr_stat && clr_hit) iif_q <= 1'b0;
      if (!en) busy_q <= 1'b0;
      else if (start_ev) busy_q <= 1'b1;
      else if (stop_ev) busy_q <= 1'b0;

      if (!en) begin
        st <= S_IDLE; sda_oe_q <= 1'b0; cnt <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            cnt <= '0;
            sda_oe_q <= 1'b0;
            if (ctrl_q[5]) begin st <= S_START; sda_oe_q <= 1'b1; end
          end
          S_START: begin
            if (cnt_end) begin cnt <= '0; st <= S_HOLD; end
            else cnt <= cnt + 1'b1;
          end
          S_HOLD: begin
            cnt <= '0;
            bitn <= '0;
            if (!ctrl_q[5]) begin st <= S_STOP; sda_oe_q <= 1'b1; end
            else if (ctrl_q[2]) st <= S_RSTA;
            else if (wr_dat && ctrl_q[4]) begin st <= S_BYTE; rx_q <= 1'b0; tcf_q <= 1'b0; end
            else if (rd_dat && !ctrl_q[4]) begin st <= S_BYTE; rx_q <= 1'b1; tcf_q <= 1'b0; end
          end
          S_BYTE: begin
            if (cnt == qtr)
              sda_oe_q <= (bitn < 4'd8) ? (~rx_q & ~dat_q[7]) : (rx_q & ~ctrl_q[3]);
            if (cnt == smp) begin
              if (bitn < 4'd8) dat_q <= {dat_q[6:0], sda_in};
              else if (!rx_q) rxak_q <= sda_in;
            end
            if (cnt_end) begin
              cnt <= '0;
              if (bitn == 4'd8) begin st <= S_HOLD; tcf_q <= 1'b1; end
              else bitn <= bitn + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_RSTA: begin
            if (cnt == qtr) sda_oe_q <= 1'b0;
            if (cnt_end) begin cnt <= '0; st <= S_START; sda_oe_q <= 1'b1; end
            else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (cnt == smp) sda_oe_q <= 1'b0;
            if (cnt_end) begin cnt <= '0; st <= S_IDLE; end
            else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [2:0] st,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       scl_in,
  input logic       sda_in,
  input logic       busy,
  input logic       iif
);
  localparam logic [2:0] C_HOLD = 3'd2, C_BYTE = 3'd3;

  // R12
  sda_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_BYTE && $past(st) == C_BYTE && sda_oe != $past(sda_oe)) |-> scl_oe);

  // R9
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe));

  // R2
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(scl_in) && !$past(sda_in)));

  // R6
  stop_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(en)) |-> ($past(scl_in) && $past(sda_in)));

  // R4
  iif_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iif) |-> (st == C_HOLD && scl_oe));
endmodule

bind i2c_byte_master i2c_byte_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .st(st), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .scl_in(scl_in), .sda_in(sda_in), .busy(busy_q), .iif(iif_q)
);

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_OWN = 5'd0, A_DIV = 5'd4, A_CTL = 5'd8,
                         A_STAT = 5'd12, A_DAT = 5'd16;
  localparam int NV = 5;
  localparam logic [8:0] TXV [NV] = '{9'h14B, 9'h078, 9'h1FF, 9'h000, 9'h103};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, scl_oe, sda_oe, scl_in, sda_in;

  int total = 0, bad = 0, cyc = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, last_rise = 0, prev_rise = 0;
  int bitcnt = 9;
  logic sclp = 1'b1, sdap = 1'b1;
  logic [7:0] mon_sh = '0, mon_byte = '0;
  logic mon_ack = 1'b0, nak_seen = 1'b0;
  logic slv_rx = 1'b0, ack_en = 1'b0;
  logic [7:0] rx_byte = '0;
  logic slv_drv;

  always #(CLK_P/2) clk = ~clk;

  assign slv_drv = (bitcnt < 8 && slv_rx && !nak_seen) ? ~rx_byte[3'(7 - bitcnt)]
                 : (bitcnt == 8 && !slv_rx && ack_en);
  assign scl_in = ~scl_oe;
  assign sda_in = ~(sda_oe | slv_drv);

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .scl_oe(scl_oe),
    .scl_in(scl_in), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    sclp <= scl_in;
    sdap <= sda_in;
    if (scl_in && sclp && sdap && !sda_in) begin
      n_start <= n_start + 1; bitcnt <= 9; nak_seen <= 1'b0;
    end else if (scl_in && sclp && !sdap && sda_in) n_stop <= n_stop + 1;
    else if (scl_in && !sclp) begin
      n_rise <= n_rise + 1; prev_rise <= last_rise; last_rise <= cyc;
      if (bitcnt < 8) mon_sh <= {mon_sh[6:0], sda_in};
      else if (bitcnt == 8) begin
        mon_byte <= mon_sh; mon_ack <= sda_in;
        if (slv_rx && sda_in) nak_seen <= 1'b1;
      end
    end else if (!scl_in && sclp) bitcnt <= (bitcnt >= 8) ? 0 : bitcnt + 1;
  end

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [4:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [4:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] peek(input logic [4:0] a);
    bus_addr = a;
    return bus_rdata;
  endfunction

  task automatic wait_iif(input string tag);
    int n = 0;
    logic [7:0] s;
    bus_addr = A_STAT;
    #1 s = bus_rdata;
    while (!s[1] && n < 20000) begin
      @(negedge clk); n++;
      bus_addr = A_STAT;
      #1 s = bus_rdata;
    end
    if (n >= 20000) check(0, 1, tag);
    @(negedge clk);
  endtask

  task automatic stat_bit(input int b, input int exp, input string tag);
    logic [7:0] s;
    br(A_STAT, s);
    check(int'(s[b]), exp, tag);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int r0, s0, st0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    br(A_OWN, d);  check(d, 0, "R1 own reset");
    br(A_DIV, d);  check(d, 0, "R1 div reset");
    br(A_CTL, d);  check(d, 0, "R1 ctrl reset");
    br(A_STAT, d); check(d, 0, "R1 status reset");
    br(A_DAT, d);  check(d, 0, "R1 data reset");
    bw(A_OWN, 8'h5A); br(A_OWN, d); check(d, 8'h5A, "R1 own readback");
    bw(A_DIV, 8'h20); br(A_DIV, d); check(d, 8'h20, "R1 div readback");
    bw(5'd5, 8'h3F);  br(A_DIV, d); check(d, 8'h20, "R1 misaligned write ignored");
    br(5'd6, d); check(d, 0, "R1 misaligned read zero");

    // R9 disabled: no START
    bw(A_CTL, 8'h20);
    repeat (100) @(negedge clk);
    check(n_start, 0, "R9 no start when disabled");
    check({scl_in, sda_in}, 2'b11, "R9 lines released when disabled");
    stat_bit(5, 0, "R9 busy low when disabled");

    // R2 START
    bw(A_CTL, 8'h80);
    bw(A_CTL, 8'hF0);
    repeat (60) @(negedge clk);
    check(n_start, 1, "R2 one START");
    stat_bit(5, 1, "R2 busy set");
    check(int'(scl_in), 0, "R2 SCL held low");
    stat_bit(1, 0, "R4 flag clear before byte");

    // vector table: R3 R4 R8 R11 R12
    for (int i = 0; i < NV; i++) begin
      ack_en = TXV[i][0];
      bw(A_DAT, TXV[i][8:1]);
      wait_iif("R4 byte done timeout");
      check(mon_byte, TXV[i][8:1], "R3 R12 byte on wire");
      stat_bit(0, int'(!TXV[i][0]), "R3 ack sampled");
      stat_bit(7, 1, "R4 transfer complete");
      check(int'(irq), 1, "R11 irq with enable");
      if (i == 0) begin
        check(last_rise - prev_rise, 22, "R10 period code 0x20");
        r0 = n_rise;
        repeat (60) @(negedge clk);
        check(n_rise, r0, "R4 no clocks while holding");
        check(int'(scl_in), 0, "R4 SCL low while holding");
        bw(A_STAT, 8'h02);
        stat_bit(1, 1, "R8 write one keeps flag");
      end
      if (i == 1) begin
        bw(A_CTL, 8'hB0);
        check(int'(irq), 0, "R11 irq gated off");
        bw(A_CTL, 8'hF0);
      end
      bw(A_STAT, 8'h00);
      stat_bit(1, 0, "R8 write zero clears flag");
      check(int'(irq), 0, "R11 irq low after clear");
    end

    // R10 other codes
    bw(A_DIV, 8'h00); bw(A_DAT, 8'h66); wait_iif("R10 timeout");
    check(last_rise - prev_rise, 30, "R10 period code 0x00");
    bw(A_STAT, 8'h00);
    bw(A_DIV, 8'h2A); bw(A_DAT, 8'h99); wait_iif("R10 timeout");
    check(last_rise - prev_rise, 64, "R10 period code 0x2A");
    bw(A_STAT, 8'h00);
    bw(A_DIV, 8'h20);

    // R13 set and clear on same edge
    bw(A_DAT, 8'hC7);
    repeat (9 * 22 - 1) @(negedge clk);
    bw(A_STAT, 8'h00);
    stat_bit(1, 1, "R13 set wins over clear");
    bw(A_STAT, 8'h00);
    stat_bit(1, 0, "R13 later clear works");

    // R7 repeated start
    st0 = n_start; s0 = n_stop;
    bw(A_CTL, 8'hF4);
    repeat (80) @(negedge clk);
    check(n_start, st0 + 1, "R7 repeated START seen");
    check(n_stop, s0, "R7 no STOP between");
    stat_bit(5, 1, "R7 busy kept");
    br(A_CTL, d); check(int'(d[2]), 0, "R7 restart bit self clears");

    // R5 receive, R6 stop
    ack_en = 1'b1;
    bw(A_DAT, 8'hA1); wait_iif("R5 timeout"); bw(A_STAT, 8'h00);
    bw(A_CTL, 8'hE0);
    rx_byte = 8'hC3; slv_rx = 1'b1;
    br(A_DAT, d);
    wait_iif("R5 timeout");
    check(int'(mon_ack), 0, "R5 master acks with TXAK 0");
    bw(A_STAT, 8'h00);
    bw(A_CTL, 8'hE8);
    rx_byte = 8'h5E;
    br(A_DAT, d); check(d, 8'hC3, "R5 first byte received");
    wait_iif("R5 timeout");
    check(int'(mon_ack), 1, "R5 master releases with TXAK 1");
    bw(A_STAT, 8'h00);
    r0 = n_rise; s0 = n_stop;
    bw(A_CTL, 8'hC0);
    repeat (60) @(negedge clk);
    check(n_stop, s0 + 1, "R6 STOP made");
    check(n_rise, r0 + 1, "R6 only the STOP clock");
    stat_bit(5, 0, "R6 busy cleared");
    br(A_DAT, d); check(d, 8'h5E, "R5 last byte received");
    slv_rx = 1'b0;

    // R9 disable mid transfer
    bw(A_CTL, 8'hF0);
    repeat (60) @(negedge clk);
    bw(A_DAT, 8'h55);
    repeat (50) @(negedge clk);
    bw(A_CTL, 8'h00);
    repeat (3) @(negedge clk);
    check({scl_in, sda_in}, 2'b11, "R9 lines released on disable");
    stat_bit(5, 0, "R9 busy cleared on disable");

    finish_run();
  end
endmodule